// File: doc/BRIEF.md
# IR Receive Byte Queue with Status

This block sits between the pulse sampler of an infrared receiver and a register interface. Each run byte the sampler produces is pushed into a first-in first-out queue whose depth is a parameter (16 or 64 entries are the expected builds). Software drains the queue one byte per read strobe. It watches a status word that shows the live occupancy next to three sticky event flags: queue overflow, end of packet, and occupancy above a programmable level.

A control word carries one enable per event flag and the level threshold. The interrupt line is asserted while any enabled flag is pending. Software clears flags by writing ones into their positions of the status word. A clear leaves flags whose bits are written as zero untouched. The level flag comes back at once if the occupancy is still above the threshold.

Top module: `ir_rxq_top`

## Requirements
- R1: After reset the status word, the read word and the interrupt line are all zero.
- R2: Bytes leave the queue in the order they were accepted. The read word carries the head byte in bits 7:0 with zeros above, and each read strobe on a non-empty queue removes that byte.
- R3: Status bits starting at bit 8 hold the current occupancy, and the field is wide enough to show the full depth. A cycle with no push and no read strobe leaves the occupancy unchanged.
- R4: A push into a full queue with no read strobe in the same cycle discards the byte, leaves the stored contents and the occupancy unchanged, and sets the sticky overflow flag in status bit 0.
- R5: A packet-end pulse sets the sticky packet flag in status bit 1 on the next cycle, and the flag stays set until it is cleared.
- R6: Status bit 4 becomes set one cycle after the occupancy is strictly greater than the level field of the control word (bits starting at 8, same width as the occupancy field), and it stays set until cleared.
- R7: A clear strobe clears each of status bits 0, 1 and 4 whose bit is one in the clear word and leaves the others. Bit 4 stays set if its condition still holds.
- R8: The interrupt output is high exactly when some pending flag has its enable set in the control word: bit 0 for overflow, bit 1 for packet end, bit 4 for level reached.
- R9: A read strobe on an empty queue returns zero, leaves the occupancy at zero, and does not disturb the order of later bytes.
- R10: A push and a read strobe in the same cycle on a full queue both take effect: the head leaves, the new byte is stored, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | Push strobe from the sampler |
| wr_byte_i | input | 8 | Run byte to push |
| pkt_end_i | input | 1 | Packet-end pulse |
| rd_stb_i | input | 1 | Data read strobe; pops the head byte |
| ctl_word_i | input | 32 | Enables in bits 0, 1, 4; level threshold from bit 8 |
| clr_stb_i | input | 1 | Status clear strobe |
| clr_word_i | input | 32 | Write-one-to-clear mask for status bits 0, 1, 4 |
| rd_word_o | output | 32 | Head byte in bits 7:0, zero when empty |
| stat_word_o | output | 32 | Flags in bits 0, 1, 4; occupancy from bit 8 |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted pointer shows up on the first read after it: the head byte differs from the bench's queue model, or a byte appears early or twice. A wrong occupancy count shows in the status field on the next cycle. It also moves the level flag, whose edge is checked against every threshold at every fill level. A lost or stuck flag is seen one cycle after the event or the clear, and again on the interrupt line under each enable combination.

// File: rtl/ir_rxq_pkg.sv
package ir_rxq_pkg;
   localparam int WORD_W  = 32;
   localparam int BYTE_W  = 8;
   localparam int OVF_BIT = 0;
   localparam int PKT_BIT = 1;
   localparam int AVL_BIT = 4;
   localparam int CNT_LSB = 8;
   localparam int CNT_MAX_W = 8;

   typedef struct packed {
      logic avl;
      logic pkt;
      logic ovf;
   } evt_flags_t;
endpackage

// File: rtl/ir_rxq_store.sv
module ir_rxq_store #(
   parameter int DEPTH       = 16,
   parameter int DATA_W      = 8,
   parameter bit CLEAR_STORE = 1'b0,
   localparam int PTR_W      = $clog2(DEPTH),
   localparam int CNT_W      = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              drop_o
);
   logic [PTR_W-1:0]        wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]        count_q;
   logic [DEPTH*DATA_W-1:0] slot_vec;
   logic                    full, empty, pop_ok, push_ok;

   assign full    = (count_q == CNT_W'(DEPTH));
   assign empty   = (count_q == '0);
   assign pop_ok  = rd_i & ~empty;
   assign push_ok = wr_i & (~full | pop_ok);
   assign drop_o  = wr_i & full & ~pop_ok;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      logic              hit;
      assign hit = push_ok && (wr_ptr_q == PTR_W'(e));
      if (CLEAR_STORE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= wr_data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) slot_q <= wr_data_i;
         end
      end
      assign slot_vec[e*DATA_W +: DATA_W] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign rd_data_o = empty ? '0 : slot_vec[rd_ptr_q*DATA_W +: DATA_W];
   assign count_o   = count_q;
endmodule

// File: rtl/ir_rxq_flags.sv
module ir_rxq_flags
   import ir_rxq_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_set_i,
   input  logic             pkt_set_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] level_i,
   input  evt_flags_t       clr_i,
   input  evt_flags_t       en_i,
   output evt_flags_t       flags_o,
   output logic             irq_o
);
   evt_flags_t flags_q, set_v;

   always_comb begin
      set_v.ovf = ovf_set_i;
      set_v.pkt = pkt_set_i;
      set_v.avl = (count_i > level_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_v;
   end

   assign flags_o = flags_q;
   assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/ir_rxq_regmap.sv
module ir_rxq_regmap
   import ir_rxq_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic [WORD_W-1:0] ctl_word_i,
   input  logic              clr_stb_i,
   input  logic [WORD_W-1:0] clr_word_i,
   input  evt_flags_t        flags_i,
   input  logic [CNT_W-1:0]  count_i,
   output evt_flags_t        en_o,
   output evt_flags_t        clr_o,
   output logic [CNT_W-1:0]  level_o,
   output logic [WORD_W-1:0] stat_word_o
);
   always_comb begin
      en_o.ovf  = ctl_word_i[OVF_BIT];
      en_o.pkt  = ctl_word_i[PKT_BIT];
      en_o.avl  = ctl_word_i[AVL_BIT];
      level_o   = ctl_word_i[CNT_LSB +: CNT_W];
      clr_o.ovf = clr_stb_i & clr_word_i[OVF_BIT];
      clr_o.pkt = clr_stb_i & clr_word_i[PKT_BIT];
      clr_o.avl = clr_stb_i & clr_word_i[AVL_BIT];
   end

   always_comb begin
      stat_word_o                     = '0;
      stat_word_o[OVF_BIT]            = flags_i.ovf;
      stat_word_o[PKT_BIT]            = flags_i.pkt;
      stat_word_o[AVL_BIT]            = flags_i.avl;
      stat_word_o[CNT_LSB +: CNT_W]   = count_i;
   end
endmodule

// File: rtl/ir_rxq_top.sv
module ir_rxq_top
   import ir_rxq_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter bit CLEAR_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb_i,
   input  logic [7:0]        wr_byte_i,
   input  logic              pkt_end_i,
   input  logic              rd_stb_i,
   input  logic [31:0]       ctl_word_i,
   input  logic              clr_stb_i,
   input  logic [31:0]       clr_word_i,
   output logic [31:0]       rd_word_o,
   output logic [31:0]       stat_word_o,
   output logic              irq_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ir_rxq_top: DEPTH must be a power of two of at least 4");
   end
   if (CNT_W > CNT_MAX_W) begin : g_bad_width
      $error("ir_rxq_top: occupancy field does not fit its 8-bit slot");
   end

   logic [BYTE_W-1:0] head_byte;
   logic [CNT_W-1:0]  count, level;
   logic              drop;
   evt_flags_t        flags, en, clr;

   ir_rxq_store #(
      .DEPTH      (DEPTH),
      .DATA_W     (BYTE_W),
      .CLEAR_STORE(CLEAR_STORE)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_stb_i),
      .wr_data_i(wr_byte_i),
      .rd_i     (rd_stb_i),
      .rd_data_o(head_byte),
      .count_o  (count),
      .drop_o   (drop)
   );

   ir_rxq_regmap #(.CNT_W(CNT_W)) u_regmap (
      .ctl_word_i (ctl_word_i),
      .clr_stb_i  (clr_stb_i),
      .clr_word_i (clr_word_i),
      .flags_i    (flags),
      .count_i    (count),
      .en_o       (en),
      .clr_o      (clr),
      .level_o    (level),
      .stat_word_o(stat_word_o)
   );

   ir_rxq_flags #(.CNT_W(CNT_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_set_i(drop),
      .pkt_set_i(pkt_end_i),
      .count_i  (count),
      .level_i  (level),
      .clr_i    (clr),
      .en_i     (en),
      .flags_o  (flags),
      .irq_o    (irq_o)
   );

   assign rd_word_o = {{(WORD_W-BYTE_W){1'b0}}, head_byte};
endmodule

// File: rtl/ir_rxq_chk.sv
module ir_rxq_chk #(
   parameter int DEPTH = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_stb_i,
   input logic        pkt_end_i,
   input logic        rd_stb_i,
   input logic [31:0] ctl_word_i,
   input logic        clr_stb_i,
   input logic [31:0] clr_word_i,
   input logic [31:0] rd_word_o,
   input logic [31:0] stat_word_o,
   input logic        irq_o
);
   localparam int CNT_W = $clog2(DEPTH) + 1;
   logic [CNT_W-1:0] occ, lvl;
   assign occ = stat_word_o[8 +: CNT_W];
   assign lvl = ctl_word_i[8 +: CNT_W];

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));
   p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb_i && !rd_stb_i) |=> $stable(occ));
   p_ovf_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_i && !rd_stb_i && occ == CNT_W'(DEPTH)) |=> (stat_word_o[0] && occ == CNT_W'(DEPTH)));
   p_pkt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end_i |=> stat_word_o[1]);
   p_avl_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_word_o[4]) |-> ($past(occ) > $past(lvl)));
   p_pkt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word_o[1] && !(clr_stb_i && clr_word_i[1])) |=> stat_word_o[1]);
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_word_i[0] && !ctl_word_i[1] && !ctl_word_i[4]) |-> !irq_o);
   p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> (rd_word_o == '0));
   p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0 && rd_stb_i && !wr_stb_i) |=> (occ == '0));
endmodule

bind ir_rxq_top ir_rxq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb_i   (wr_stb_i),
   .pkt_end_i  (pkt_end_i),
   .rd_stb_i   (rd_stb_i),
   .ctl_word_i (ctl_word_i),
   .clr_stb_i  (clr_stb_i),
   .clr_word_i (clr_word_i),
   .rd_word_o  (rd_word_o),
   .stat_word_o(stat_word_o),
   .irq_o      (irq_o)
);

// File: tb/tb_ir_rxq_top.sv
`timescale 1ns/1ps
module tb_ir_rxq_top;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb_i = 1'b0;
   logic [7:0]  wr_byte_i = '0;
   logic        pkt_end_i = 1'b0;
   logic        rd_stb_i = 1'b0;
   logic [31:0] ctl_word_i = '0;
   logic        clr_stb_i = 1'b0;
   logic [31:0] clr_word_i = '0;
   logic [31:0] rd_word_o, stat_word_o;
   logic        irq_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] model_q[$];

   always #2 clk = ~clk;

   ir_rxq_top #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_i), .wr_byte_i(wr_byte_i),
      .pkt_end_i(pkt_end_i), .rd_stb_i(rd_stb_i), .ctl_word_i(ctl_word_i),
      .clr_stb_i(clr_stb_i), .clr_word_i(clr_word_i), .rd_word_o(rd_word_o),
      .stat_word_o(stat_word_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] b);
      wr_stb_i = 1'b1; wr_byte_i = b;
      tick();
      wr_stb_i = 1'b0;
      if (model_q.size() < DEPTH) model_q.push_back(b);
   endtask

   task automatic pop();
      rd_stb_i = 1'b1;
      tick();
      rd_stb_i = 1'b0;
      if (model_q.size() > 0) void'(model_q.pop_front());
   endtask

   task automatic clear(input logic [31:0] m);
      clr_stb_i = 1'b1; clr_word_i = m;
      tick();
      clr_stb_i = 1'b0; clr_word_i = '0;
   endtask

   task automatic drain();
      while (model_q.size() > 0) pop();
   endtask

   function automatic logic [31:0] occ();
      return {27'd0, stat_word_o[12:8]};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 stat", stat_word_o, 32'h0);
      check("R1 rd", rd_word_o, 32'h0);
      check("R1 irq", {31'd0, irq_o}, 32'h0);
      ctl_word_i = 32'h0000_1F00;

      // R3 occupancy during fill, R2 head byte
      for (int i = 0; i < DEPTH; i++) begin
         push(8'(i * 29 + 7));
         check("R3 fill count", occ(), 32'(i + 1));
         check("R2 head", rd_word_o, {24'd0, model_q[0]});
      end
      // R4 overflow drop
      push(8'hEE);
      check("R4 count held", occ(), 32'(DEPTH));
      check("R4 ovf flag", {31'd0, stat_word_o[0]}, 32'h1);
      clear(32'h1);
      check("R7 ovf cleared", {31'd0, stat_word_o[0]}, 32'h0);
      // R10 push and pop together when full
      wr_stb_i = 1'b1; wr_byte_i = 8'h5A; rd_stb_i = 1'b1;
      tick();
      wr_stb_i = 1'b0; rd_stb_i = 1'b0;
      void'(model_q.pop_front()); model_q.push_back(8'h5A);
      check("R10 count", occ(), 32'(DEPTH));
      check("R10 no ovf", {31'd0, stat_word_o[0]}, 32'h0);
      // R2 drain order
      while (model_q.size() > 0) begin
         check("R2 order", rd_word_o, {24'd0, model_q[0]});
         pop();
         check("R3 drain count", occ(), 32'(model_q.size()));
      end
      // R9 empty read
      pop();
      check("R9 rd zero", rd_word_o, 32'h0);
      check("R9 count zero", occ(), 32'h0);
      push(8'h33);
      push(8'h44);
      check("R9 later head", rd_word_o, 32'h33);
      pop();
      check("R9 later second", rd_word_o, 32'h44);
      drain();

      // R5 packet end sticky, R7 partial clears
      pkt_end_i = 1'b1; tick(); pkt_end_i = 1'b0;
      check("R5 pkt set", {31'd0, stat_word_o[1]}, 32'h1);
      repeat (3) tick();
      check("R5 pkt sticky", {31'd0, stat_word_o[1]}, 32'h1);
      clear(32'hFFFF_FFED);
      check("R7 other-bit clear keeps pkt", {31'd0, stat_word_o[1]}, 32'h1);
      clear(32'h2);
      check("R7 pkt cleared", {31'd0, stat_word_o[1]}, 32'h0);

      // R6 level sweep over every threshold and fill level
      for (int lv = 0; lv < DEPTH; lv++) begin
         drain();
         ctl_word_i = 32'(lv) << 8;
         tick();
         clear(32'hFF);
         check("R6 empty no avl", {31'd0, stat_word_o[4]}, 32'h0);
         for (int n = 1; n <= DEPTH; n++) begin
            push(8'(n));
            tick();
            check("R6 avl", {31'd0, stat_word_o[4]}, {31'd0, (n > lv)});
         end
         clear(32'h10);
         check("R7 avl re-raised", {31'd0, stat_word_o[4]}, 32'h1);
         check("R4 no spurious ovf", {31'd0, stat_word_o[0]}, 32'h0);
      end

      // R8 interrupt for each single flag under every enable combination
      for (int src = 0; src < 3; src++) begin
         drain();
         ctl_word_i = (src == 2) ? 32'h0 : 32'h0000_1F00;
         tick();
         clear(32'hFF);
         if (src == 0) begin
            for (int k = 0; k <= DEPTH; k++) push(8'(k));
         end else if (src == 1) begin
            pkt_end_i = 1'b1; tick(); pkt_end_i = 1'b0;
         end else begin
            push(8'h99);
            tick();
         end
         for (int en = 0; en < 8; en++) begin
            logic [31:0] ew;
            ew = {27'd0, en[2], 2'b00, en[1], en[0]};
            ctl_word_i = (ctl_word_i & 32'hFFFF_FF00) | ew;
            #1;
            check("R8 irq", {31'd0, irq_o}, {31'd0, en[src]});
         end
      end
      finish_run();
   end
endmodule